// File: doc/BRIEF.md
# Posted Write Queue with Read Bypass

This block sits between a processor-side request port and a slower external bus. Writes are posted: they are taken into a small in-order queue at once and leave for the bus later, one at a time. Reads are not queued. A read goes straight to the bus and may overtake writes that are still waiting, as long as its region allows it. The processor therefore does not wait for slow write cycles before it can fetch data.

Each request carries a serialized flag from an address-attribute unit. A serialized read is held back until every older write has completed on the bus. Any read, flagged or not, is also held while its word address matches a write that is still queued. A barrier request is accepted only once the queue is empty and no bus cycle is in flight, so the core stalls behind it until the bus is idle. The bus side uses a plain valid/ready request handshake, a one-cycle completion pulse and read data that arrives with that pulse. At most one bus cycle is outstanding at a time.

Top module: `wrq_bypass`

## Requirements
- R1: After reset the queue is empty and no bus cycle is in flight: `bus_valid` and `cpu_rvalid` are low, and a barrier request is accepted in the first cycle it is offered.
- R2: A write (`cpu_op` = 1) is accepted in the same cycle it is offered whenever the queue is not full, without waiting for the bus.
- R3: When DEPTH writes are held, `cpu_ready` stays low for a write request until an entry leaves for the bus.
- R4: Writes appear on the bus in the order they were accepted, carrying the same address, data and byte enables.
- R5: Only one bus cycle is outstanding at a time. A read (`cpu_op` = 0) is accepted in the same cycle its bus handshake occurs, and its data returns on `cpu_rdata` with `cpu_rvalid` in the cycle `bus_done` completes that read.
- R6: A read that is not serialized and whose word address matches no queued write is issued ahead of older queued writes. When no write is already being offered, the read wins the bus over the queue head.
- R7: A read whose word address (address bits 31:2) equals that of any write still in the queue is not issued until that write has left the queue.
- R8: A read with `cpu_serial` high is issued only after every older write has completed on the bus.
- R9: A barrier (`cpu_op` = 2 or 3) is accepted only when the queue is empty and no bus cycle is outstanding.
- R10: Once `bus_valid` is raised, it stays high with an unchanged address and direction until `bus_ready` is seen.
- R11: Every read returns the value that results from all older writes to that word, merged byte by byte according to their enables.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_valid | input | 1 | Processor request valid |
| cpu_ready | output | 1 | Request accepted this cycle |
| cpu_op | input | 2 | 0 read, 1 write, 2 or 3 barrier |
| cpu_serial | input | 1 | Request targets a serialized region |
| cpu_addr | input | AW | Byte address |
| cpu_wdata | input | DW | Write data |
| cpu_be | input | DW/8 | Write byte enables |
| cpu_rvalid | output | 1 | Read data valid |
| cpu_rdata | output | DW | Read data |
| bus_valid | output | 1 | Bus request valid |
| bus_ready | input | 1 | Bus accepts the request |
| bus_write | output | 1 | Bus request is a write |
| bus_addr | output | AW | Bus byte address |
| bus_wdata | output | DW | Bus write data |
| bus_be | output | DW/8 | Bus byte enables (all ones on reads) |
| bus_done | input | 1 | Outstanding bus cycle completes |
| bus_rdata | input | DW | Read data, valid with bus_done |

## Verification
A corrupted queue pointer or count shows up at the bus port on the next write drain. The entry leaves out of order or with the wrong payload, or the write port stalls at the wrong fill level in the very cycle it is offered. A comparator fault or a lost serialized flag appears as stale read data, returned on the completion pulse of that same read. The bench catches it by comparing against a program-order memory. A wrong outstanding-cycle flag shows up within one cycle, as a second bus request before completion or as a barrier accepted with writes still pending.

// File: rtl/wrq_pkg.sv
package wrq_pkg;

   // Request codes on the processor port; both codes with bit 1 set are barriers.
   typedef enum logic [1:0] {
      OP_RD        = 2'd0,
      OP_WR        = 2'd1,
      OP_FENCE     = 2'd2,
      OP_FENCE_ALT = 2'd3
   } wrq_op_e;

   function automatic logic wrq_is_fence(input logic [1:0] op);
      return op[1];
   endfunction

endpackage

// File: rtl/wrq_match.sv
module wrq_match #(
   parameter int DEPTH = 4,
   parameter int WAW   = 30
) (
   input  logic [DEPTH-1:0]          ent_vld,
   input  logic [DEPTH-1:0][WAW-1:0] ent_word,
   input  logic [WAW-1:0]            look_word,
   output logic                      hit
);

   logic [DEPTH-1:0] hit_vec;

   // One word comparator per queue slot, all evaluated in parallel.
   for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
      assign hit_vec[i] = ent_vld[i] && (ent_word[i] == look_word);
   end

   assign hit = |hit_vec;

endmodule

// File: rtl/wrq_store.sv
module wrq_store #(
   parameter int DEPTH = 4,
   parameter int AW    = 32,
   parameter int DW    = 32,
   parameter int BW    = DW / 8,
   parameter int LSB   = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push,
   input  logic [AW-1:0] push_addr,
   input  logic [DW-1:0] push_data,
   input  logic [BW-1:0] push_be,
   input  logic          pop,
   output logic [AW-1:0] head_addr,
   output logic [DW-1:0] head_data,
   output logic [BW-1:0] head_be,
   output logic          full,
   output logic          empty,
   input  logic [AW-LSB-1:0] look_word,
   output logic          hit
);

   localparam int PW  = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CW  = $clog2(DEPTH + 1);
   localparam int WAW = AW - LSB;
   localparam bit POW2 = ((DEPTH & (DEPTH - 1)) == 0);

   logic [AW-1:0]  addr_q [DEPTH];
   logic [DW-1:0]  data_q [DEPTH];
   logic [BW-1:0]  be_q   [DEPTH];
   logic [DEPTH-1:0] vld_q;
   logic [PW-1:0]  wr_ptr, rd_ptr, wr_nxt, rd_nxt;
   logic [CW-1:0]  cnt_q;
   logic [DEPTH-1:0][WAW-1:0] word_w;

   // Pointer advance: free wrap for power-of-two depths, explicit wrap otherwise.
   if (POW2) begin : g_pow2
      assign wr_nxt = wr_ptr + 1'b1;
      assign rd_nxt = rd_ptr + 1'b1;
   end else begin : g_wrap
      assign wr_nxt = (wr_ptr == PW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      assign rd_nxt = (rd_ptr == PW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         cnt_q  <= '0;
         vld_q  <= '0;
      end else begin
         if (push) begin
            vld_q[wr_ptr] <= 1'b1;
            wr_ptr        <= wr_nxt;
         end
         if (pop) begin
            vld_q[rd_ptr] <= 1'b0;
            rd_ptr        <= rd_nxt;
         end
         case ({push, pop})
            2'b10:   cnt_q <= cnt_q + 1'b1;
            2'b01:   cnt_q <= cnt_q - 1'b1;
            default: cnt_q <= cnt_q;
         endcase
      end
   end

   // Payload storage carries no reset; validity lives in vld_q.
   always_ff @(posedge clk) begin
      if (push) begin
         addr_q[wr_ptr] <= push_addr;
         data_q[wr_ptr] <= push_data;
         be_q[wr_ptr]   <= push_be;
      end
   end

   assign head_addr = addr_q[rd_ptr];
   assign head_data = data_q[rd_ptr];
   assign head_be   = be_q[rd_ptr];
   assign full      = (cnt_q == CW'(DEPTH));
   assign empty     = (cnt_q == '0);

   for (genvar i = 0; i < DEPTH; i++) begin : g_word
      assign word_w[i] = addr_q[i][AW-1:LSB];
   end

   wrq_match #(
      .DEPTH (DEPTH),
      .WAW   (WAW)
   ) u_match (
      .ent_vld   (vld_q),
      .ent_word  (word_w),
      .look_word (look_word),
      .hit       (hit)
   );

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      push |-> !full); // R3
   AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      pop |-> !empty); // R4
   AST_VALID_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(vld_q) == int'(cnt_q)); // R1
   AST_EMPTY_NO_HIT: assert property (@(posedge clk) disable iff (!rst_n)
      empty |-> !hit); // R7

endmodule

// File: rtl/wrq_arb.sv
module wrq_arb
   import wrq_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       cpu_valid,
   input  logic [1:0] cpu_op,
   input  logic       cpu_serial,
   output logic       cpu_ready,
   output logic       cpu_rvalid,
   input  logic       q_empty,
   input  logic       q_full,
   input  logic       q_hit,
   output logic       push,
   output logic       pop,
   output logic       bus_valid,
   output logic       sel_rd,
   input  logic       bus_ready,
   input  logic       bus_done
);

   wrq_op_e op;
   logic    is_rd, is_wr, is_fence;
   logic    busy_q, busy_rd_q, wr_hold_q;
   logic    rd_ok, wr_go;

   assign op       = wrq_op_e'(cpu_op);
   assign is_rd    = (op == OP_RD);
   assign is_wr    = (op == OP_WR);
   assign is_fence = wrq_is_fence(cpu_op);

   // A read may use the bus when it is idle, no queued write is already
   // being offered, no queued write shares its word, and (if serialized)
   // every older write has left the queue and completed.
   always_comb begin
      rd_ok = cpu_valid && is_rd && !busy_q && !wr_hold_q && !q_hit &&
              (!cpu_serial || q_empty);
      wr_go = !busy_q && !q_empty && (wr_hold_q || !rd_ok);
   end

   assign bus_valid = rd_ok || wr_go;
   assign sel_rd    = rd_ok;
   assign pop       = wr_go && bus_ready;
   assign push      = cpu_valid && is_wr && !q_full;

   always_comb begin
      cpu_ready = 1'b0;
      if (is_rd)         cpu_ready = rd_ok && bus_ready;
      else if (is_wr)    cpu_ready = !q_full;
      else if (is_fence) cpu_ready = q_empty && !busy_q && !wr_hold_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q    <= 1'b0;
         busy_rd_q <= 1'b0;
         wr_hold_q <= 1'b0;
      end else begin
         wr_hold_q <= wr_go && !bus_ready;
         if (bus_valid && bus_ready) begin
            busy_q    <= 1'b1;
            busy_rd_q <= rd_ok;
         end else if (bus_done) begin
            busy_q    <= 1'b0;
            busy_rd_q <= 1'b0;
         end
      end
   end

   assign cpu_rvalid = bus_done && busy_q && busy_rd_q;

   AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
      bus_valid && bus_ready |=> !bus_valid); // R5
   AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      bus_valid && !bus_ready |=> bus_valid && $stable(sel_rd)); // R10
   AST_RVALID_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_rvalid |=> !cpu_rvalid); // R5

endmodule

// File: rtl/wrq_bypass.sv
module wrq_bypass
   import wrq_pkg::*;
#(
   parameter int DEPTH = 4,
   parameter int AW    = 32,
   parameter int DW    = 32
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            cpu_valid,
   output logic            cpu_ready,
   input  logic [1:0]      cpu_op,
   input  logic            cpu_serial,
   input  logic [AW-1:0]   cpu_addr,
   input  logic [DW-1:0]   cpu_wdata,
   input  logic [DW/8-1:0] cpu_be,
   output logic            cpu_rvalid,
   output logic [DW-1:0]   cpu_rdata,
   output logic            bus_valid,
   input  logic            bus_ready,
   output logic            bus_write,
   output logic [AW-1:0]   bus_addr,
   output logic [DW-1:0]   bus_wdata,
   output logic [DW/8-1:0] bus_be,
   input  logic            bus_done,
   input  logic [DW-1:0]   bus_rdata
);

   localparam int BW  = DW / 8;
   localparam int LSB = $clog2(BW);

   if (DEPTH < 2) begin : g_chk_depth
      $error("wrq_bypass: DEPTH must be at least 2");
   end
   if ((DW % 8) != 0 || DW < 16) begin : g_chk_dw
      $error("wrq_bypass: DW must be a multiple of 8 and at least 16");
   end
   if (AW <= LSB) begin : g_chk_aw
      $error("wrq_bypass: AW too small for the word size");
   end

   logic          push, pop, q_full, q_empty, q_hit, sel_rd;
   logic [AW-1:0] head_addr;
   logic [DW-1:0] head_data;
   logic [BW-1:0] head_be;

   wrq_store #(
      .DEPTH (DEPTH),
      .AW    (AW),
      .DW    (DW),
      .BW    (BW),
      .LSB   (LSB)
   ) u_store (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (push),
      .push_addr (cpu_addr),
      .push_data (cpu_wdata),
      .push_be   (cpu_be),
      .pop       (pop),
      .head_addr (head_addr),
      .head_data (head_data),
      .head_be   (head_be),
      .full      (q_full),
      .empty     (q_empty),
      .look_word (cpu_addr[AW-1:LSB]),
      .hit       (q_hit)
   );

   wrq_arb u_arb (
      .clk        (clk),
      .rst_n      (rst_n),
      .cpu_valid  (cpu_valid),
      .cpu_op     (cpu_op),
      .cpu_serial (cpu_serial),
      .cpu_ready  (cpu_ready),
      .cpu_rvalid (cpu_rvalid),
      .q_empty    (q_empty),
      .q_full     (q_full),
      .q_hit      (q_hit),
      .push       (push),
      .pop        (pop),
      .bus_valid  (bus_valid),
      .sel_rd     (sel_rd),
      .bus_ready  (bus_ready),
      .bus_done   (bus_done)
   );

   // The bus carries either the waiting read or the queue head.
   assign bus_write = !sel_rd;
   assign bus_addr  = sel_rd ? cpu_addr : head_addr;
   assign bus_wdata = sel_rd ? '0 : head_data;
   assign bus_be    = sel_rd ? '1 : head_be;
   assign cpu_rdata = bus_rdata;

   AST_SERIAL_DRAINED: assert property (@(posedge clk) disable iff (!rst_n)
      bus_valid && !bus_write && cpu_serial |-> q_empty); // R8
   AST_READ_NO_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
      bus_valid && !bus_write |-> !q_hit); // R7
   AST_FENCE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_valid && cpu_ready && cpu_op[1] |-> q_empty && !bus_valid); // R9
   AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      bus_valid && !bus_ready |=> $stable(bus_addr)); // R10
   AST_WRITE_POSTED: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_valid && cpu_op == 2'd1 && !q_full |-> cpu_ready); // R2

endmodule

// File: tb/wrq_bypass_tb_top.sv
`timescale 1ns/1ps
module wrq_bypass_tb_top;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #10 clk = ~clk;

   logic        cpu_valid = 1'b0;
   logic [1:0]  cpu_op = 2'd0;
   logic        cpu_serial = 1'b0;
   logic [31:0] cpu_addr = '0;
   logic [31:0] cpu_wdata = '0;
   logic [3:0]  cpu_be = '0;
   logic        cpu_ready, cpu_rvalid;
   logic [31:0] cpu_rdata;
   logic        bus_valid, bus_write;
   logic [31:0] bus_addr, bus_wdata;
   logic [3:0]  bus_be;
   logic        bus_ready = 1'b0;
   logic        bus_done = 1'b0;
   logic [31:0] bus_rdata = '0;

   wrq_bypass dut_i (
      .clk(clk), .rst_n(rst_n),
      .cpu_valid(cpu_valid), .cpu_ready(cpu_ready), .cpu_op(cpu_op),
      .cpu_serial(cpu_serial), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
      .cpu_be(cpu_be), .cpu_rvalid(cpu_rvalid), .cpu_rdata(cpu_rdata),
      .bus_valid(bus_valid), .bus_ready(bus_ready), .bus_write(bus_write),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_be(bus_be),
      .bus_done(bus_done), .bus_rdata(bus_rdata)
   );

   localparam logic [31:0] BASE = 32'h1000_0000;

   int checks = 0;
   int errors = 0;

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   function automatic logic [31:0] merge(input logic [31:0] old_v,
                                         input logic [31:0] new_v,
                                         input logic [3:0] be);
      logic [31:0] r = old_v;
      for (int b = 0; b < 4; b++) if (be[b]) r[8*b +: 8] = new_v[8*b +: 8];
      return r;
   endfunction

   typedef struct {
      logic [31:0] a;
      logic [31:0] d;
      logic [3:0]  b;
   } wr_t;

   logic [31:0] ref_mem [8];
   logic [31:0] bus_mem [8];
   wr_t         wq [$];
   int          wr_acc = 0, wr_done = 0;
   bit          rd_pending = 0, last_bypass = 0;
   logic [31:0] exp_rd = '0;
   bit          prev_hold = 0, prev_wr = 0;
   logic [31:0] prev_addr = '0;

   // bus model state
   bit          stall = 0, always_rdy = 0;
   int          fixed_lat = -1;
   bit          out_active = 0, out_wr = 0, done_wr = 0, hs_flag = 0, hs_wr = 0;
   logic [31:0] out_addr = '0, out_data = '0, hs_addr = '0, hs_data = '0;
   logic [3:0]  out_be = '0, hs_be = '0;
   int          lat_left = 0;

   initial begin
      for (int i = 0; i < 8; i++) begin
         ref_mem[i] = 32'h0101_0101 * i;
         bus_mem[i] = 32'h0101_0101 * i;
      end
   end

   // Bus model: one outstanding cycle, variable acceptance and completion delay.
   initial begin
      forever begin
         @(posedge clk); #2;
         bus_done = 1'b0;
         if (out_active) begin
            if (lat_left == 0) begin
               if (out_wr) bus_mem[out_addr[4:2]] = merge(bus_mem[out_addr[4:2]], out_data, out_be);
               else bus_rdata = bus_mem[out_addr[4:2]];
               done_wr = out_wr;
               bus_done = 1'b1;
               out_active = 0;
            end else lat_left--;
         end
         if (hs_flag) begin
            hs_flag = 0;
            out_active = 1;
            out_wr = hs_wr; out_addr = hs_addr; out_data = hs_data; out_be = hs_be;
            lat_left = (fixed_lat >= 0) ? fixed_lat : int'($urandom % 4);
         end
         bus_ready = stall ? 1'b0 : (always_rdy ? 1'b1 : (($urandom % 4) != 0));
      end
   end

   // Monitor: mid-cycle sampling of handshakes and responses.
   always @(negedge clk) begin
      if (rst_n) begin
         if (prev_hold)
            chk(bus_valid && bus_addr == prev_addr && bus_write == prev_wr, "R10",
                "request held until ready", {bus_valid, bus_addr}, {1'b1, prev_addr});
         prev_hold = bus_valid && !bus_ready;
         prev_addr = bus_addr;
         prev_wr   = bus_write;

         if (bus_done) begin
            if (done_wr) wr_done++;
            else chk(cpu_rvalid, "R5", "read completion reaches core", cpu_rvalid, 1);
         end else if (cpu_rvalid) begin
            chk(0, "R5", "rvalid without read completion", 1, 0);
         end
         if (cpu_rvalid) begin
            chk(rd_pending, "R5", "response matches an issued read", rd_pending, 1);
            chk(cpu_rdata == exp_rd, "R11", "read data", cpu_rdata, exp_rd);
            rd_pending = 0;
         end

         if (bus_valid && bus_ready) begin
            chk(!out_active, "R5", "single outstanding bus cycle", out_active, 0);
            hs_flag = 1; hs_wr = bus_write; hs_addr = bus_addr; hs_data = bus_wdata; hs_be = bus_be;
            if (bus_write) begin
               if (wq.size() == 0) chk(0, "R4", "unexpected bus write", bus_addr, 0);
               else begin
                  chk(bus_addr == wq[0].a && bus_wdata == wq[0].d && bus_be == wq[0].b, "R4",
                      "write order/payload", bus_addr, wq[0].a);
                  void'(wq.pop_front());
               end
            end
         end

         if (cpu_valid && cpu_ready) begin
            if (cpu_op == 2'd0) begin
               bit h = 0;
               chk(bus_valid && bus_ready && !bus_write && bus_addr == cpu_addr, "R5",
                   "read issued with acceptance", bus_addr, cpu_addr);
               exp_rd = ref_mem[cpu_addr[4:2]];
               rd_pending = 1;
               last_bypass = (wr_done < wr_acc);
               foreach (wq[i]) if (wq[i].a[31:2] == cpu_addr[31:2]) h = 1;
               chk(!h, "R7", "read issued past matching queued write", h, 0);
               if (cpu_serial)
                  chk(wr_done == wr_acc, "R8", "serialized read after all writes", wr_done, wr_acc);
            end else if (cpu_op == 2'd1) begin
               ref_mem[cpu_addr[4:2]] = merge(ref_mem[cpu_addr[4:2]], cpu_wdata, cpu_be);
               wq.push_back('{a: cpu_addr, d: cpu_wdata, b: cpu_be});
               wr_acc++;
            end else begin
               chk(wr_done == wr_acc && !out_active && wq.size() == 0, "R9",
                   "barrier only when idle", wr_acc - wr_done, 0);
            end
         end
      end
   end

   task automatic cpu_req(input logic [1:0] op, input bit ser, input logic [31:0] a,
                          input logic [31:0] d, input logic [3:0] be);
      @(posedge clk); #2;
      cpu_op = op; cpu_serial = ser; cpu_addr = a; cpu_wdata = d; cpu_be = be;
      cpu_valid = 1'b1;
      do @(negedge clk); while (!cpu_ready);
      @(posedge clk); #2;
      cpu_valid = 1'b0;
      if (op == 2'd0) while (rd_pending) @(negedge clk);
   endtask

   function automatic logic [31:0] waddr(input int idx);
      return BASE | (32'(idx & 7) << 2) | 32'($urandom % 4);
   endfunction

   // Watchdog
   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 200000, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      void'($urandom(32'h5EED_0042));
      repeat (5) @(posedge clk);
      #2 rst_n = 1'b1;

      // R1: reset state
      @(negedge clk);
      chk(!bus_valid, "R1", "bus idle after reset", bus_valid, 0);
      chk(!cpu_rvalid, "R1", "no response after reset", cpu_rvalid, 0);
      @(posedge clk); #2;
      cpu_op = 2'd2; cpu_valid = 1'b1;
      @(negedge clk);
      chk(cpu_ready, "R1", "barrier accepted at once after reset", cpu_ready, 1);
      @(posedge clk); #2; cpu_valid = 1'b0;

      // R2/R3: fill with bus stalled
      stall = 1;
      repeat (3) @(posedge clk);
      for (int i = 0; i < 4; i++) begin
         @(posedge clk); #2;
         cpu_op = 2'd1; cpu_addr = waddr(i); cpu_wdata = $urandom; cpu_be = 4'hF; cpu_valid = 1'b1;
         @(negedge clk);
         chk(cpu_ready, "R2", "write posted without bus", cpu_ready, 1);
         @(posedge clk); #2; cpu_valid = 1'b0;
      end
      @(posedge clk); #2;
      cpu_op = 2'd1; cpu_addr = waddr(4); cpu_wdata = 32'hDEAD_BEEF; cpu_be = 4'h3; cpu_valid = 1'b1;
      for (int k = 0; k < 3; k++) begin
         @(negedge clk);
         chk(!cpu_ready, "R3", "write held off when full", cpu_ready, 0);
      end
      @(posedge clk); #2;
      stall = 0;
      do @(negedge clk); while (!cpu_ready);
      @(posedge clk); #2; cpu_valid = 1'b0;
      cpu_req(2'd2, 0, 0, 0, 0);

      // R6: bypass of queued writes
      always_rdy = 1; fixed_lat = 10;
      cpu_req(2'd1, 0, waddr(0), 32'h1111_1111, 4'hF);
      repeat (3) @(posedge clk);
      cpu_req(2'd1, 0, waddr(1), 32'h2222_2222, 4'hF);
      cpu_req(2'd1, 0, waddr(2), 32'h3333_3333, 4'h5);
      cpu_req(2'd0, 0, waddr(5), 0, 0);
      chk(last_bypass, "R6", "nonserialized read overtook queued writes", last_bypass, 1);
      cpu_req(2'd2, 0, 0, 0, 0);

      // R8: serialized read waits for all writes
      cpu_req(2'd1, 0, waddr(0), 32'h4444_4444, 4'hF);
      repeat (3) @(posedge clk);
      cpu_req(2'd1, 0, waddr(1), 32'h5555_5555, 4'hF);
      cpu_req(2'd1, 0, waddr(2), 32'h6666_6666, 4'hF);
      cpu_req(2'd0, 1, waddr(5), 0, 0);
      chk(!last_bypass, "R8", "serialized read did not overtake", last_bypass, 0);
      cpu_req(2'd2, 0, 0, 0, 0);

      // R7: matching address held, younger write still bypassed
      cpu_req(2'd1, 0, waddr(0), 32'h7777_7777, 4'hF);
      repeat (3) @(posedge clk);
      cpu_req(2'd1, 0, waddr(3), 32'hA5A5_A5A5, 4'h6);
      cpu_req(2'd1, 0, waddr(4), 32'h8888_8888, 4'hF);
      cpu_req(2'd0, 0, waddr(3), 0, 0);
      chk(last_bypass, "R7", "younger unrelated write still pending", last_bypass, 1);
      cpu_req(2'd2, 0, 0, 0, 0);

      // Random traffic
      always_rdy = 0; fixed_lat = -1;
      for (int n = 0; n < 2500; n++) begin
         int r = int'($urandom % 100);
         if (r < 48) begin
            logic [3:0] be = 4'($urandom);
            if (be == 4'h0) be = 4'h8;
            cpu_req(2'd1, 0, waddr(int'($urandom % 8)), $urandom, be);
         end else if (r < 94) begin
            cpu_req(2'd0, (($urandom % 5) == 0), waddr(int'($urandom % 8)), 0, 0);
         end else begin
            cpu_req(2'(2 + ($urandom % 2)), 0, 0, 0, 0);
         end
      end
      cpu_req(2'd2, 0, 0, 0, 0);
      repeat (4) @(posedge clk);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule